// File: doc/BRIEF.md
# Edge-Latched Bridge Interrupt Controller

This block collects events from a configurable number of edge-triggered sources, up to 32, into one sticky pending register. It raises a single request line toward a parent interrupt controller. Each source passes through a two-flop synchroniser, and a rising edge on its synchronised level sets the matching pending bit. That bit is set whatever the enable register holds, so an event that occurs while its source is disabled is still recorded.

Software sees a two-word register window. The word at byte offset 0x00 holds the pending bits. The word at byte offset 0x04 holds the per-source enable bits. Software acknowledges an event by writing 0 to its pending bit; a 1 in the written word leaves that bit alone. The request output is the registered OR of the pending bits that are enabled. Beside it the block reports the lowest-numbered enabled pending source, so a handler can serve events from bit 0 upward.

A pending bit that is still set from an earlier event fires as soon as its source is enabled. For that reason software should clear the pending bit before enabling the source. At start-up software writes 0 to both words.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset the pending register, the enable register, `irq_o` and `pend_idx_o` are all 0.
- R2: A 0-to-1 change of `src_i[i]` sets pending bit i about three clock edges later: two synchroniser flops and then the latch. A level held high, or a 1-to-0 change, sets nothing.
- R3: Pending bit i is set by its edge even when enable bit i (offset 0x04, bit i) is 0. While enable bit i is 0, that bit does not drive `irq_o`.
- R4: A write to offset 0x00 clears every pending bit whose written bit is 0. A written 1 leaves the bit unchanged, so writing all ones changes nothing.
- R5: The enable register at offset 0x04 reads back what was written. In both registers, bits at positions NUM_SRC and above read as 0 and ignore writes.
- R6: `irq_o` is 1 exactly when, on the previous clock edge, some bit was set in both the pending and the enable registers.
- R7: `pend_idx_o` gives the lowest bit position that was set in both registers on the previous clock edge, and 0 when there is none. Pending bits that are not enabled are skipped.
- R8: If a new rising edge on source i and a write that clears pending bit i take effect on the same clock edge, the bit stays set.
- R9: Enabling a source whose pending bit is still set raises `irq_o` at once. Clearing that bit before enabling the source prevents the request.
- R10: A write to any address other than 0x00 or 0x04 changes no register. A read of such an address returns 0.
- R11: A read strobe returns the addressed word on `bus_rdata_o` one cycle later, with `bus_rvalid_o` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous event sources |
| bus_addr_i | input | ADDR_W | Byte address of the register word |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Request to the parent controller |
| pend_idx_o | output | 5 | Lowest enabled pending source index |

## Verification
The bench builds the block with NUM_SRC set to 20 and ADDR_W left at 4. With 20 sources, writes of all ones can show that bit positions 20 to 31 stay 0 in both registers, which the default width of 32 would hide. A four-bit address reaches the unmapped words at 0x08 and 0x0C. A scoreboard queue holds the expected read data, which the bench derives from the edges it has driven, the clears it has written and the enables it has set. One sequence is timed so that a fresh source edge and a clearing write land on the same clock edge.

// File: rtl/eib_pkg.sv
`timescale 1ns/1ps
package eib_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned OFS_PEND = 0;
    localparam int unsigned OFS_ENAB = 4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENAB
    } reg_sel_e;

    function automatic logic [REG_W-1:0] below_mask(input logic [IDX_W-1:0] idx);
        return (REG_W'(1) << idx) - REG_W'(1);
    endfunction
endpackage

// File: rtl/eib_sync_edge.sv
`timescale 1ns/1ps
module eib_sync_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // stage 0 and 1 synchronise, stage 2 holds the previous level
        logic [2:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= {stage_q[1:0], src_i[g]};
            end
        end
        assign rise_o[g] = stage_q[1] & ~stage_q[2];
    end
endmodule

// File: rtl/eib_cause_bank.sv
`timescale 1ns/1ps
module eib_cause_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] clr_data_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (clr_we_i) begin
            pend_d = pend_d & clr_data_i;
        end
        // a fresh edge wins over a clear on the same edge
        pend_d = pend_d | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R2, R8: every detected edge leaves its bit set
    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

    // R2: a bit goes from 0 to 1 only through an edge
    assert_set_only_by_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0));

    // R4: a bit falls only through a clearing write
    assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((~pend_q & $past(pend_q)) == '0));
endmodule

// File: rtl/eib_lowest_pick.sv
`timescale 1ns/1ps
module eib_lowest_pick
    import eib_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/edge_irq_bridge.sv
`timescale 1ns/1ps
module edge_irq_bridge
    import eib_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic               bus_rvalid_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   pend_idx_o
);
    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((64'd1 << NUM_SRC) - 64'd1);

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] enab_q;
    logic [NUM_SRC-1:0] active;
    logic [REG_W-1:0]   active_ext;
    logic               any_active;
    logic [IDX_W-1:0]   low_idx;
    reg_sel_e           sel;
    logic               pend_clr_we;
    logic [REG_W-1:0]   rdata_d;
    logic [REG_W-1:0]   rdata_q;
    logic               rvalid_q;
    logic               irq_q;
    logic [IDX_W-1:0]   idx_q;

    // ---------------- source front end ----------------
    eib_sync_edge #(.WIDTH(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    // ---------------- register decode ----------------
    always_comb begin
        if (bus_addr_i == ADDR_W'(OFS_PEND)) begin
            sel = SEL_PEND;
        end else if (bus_addr_i == ADDR_W'(OFS_ENAB)) begin
            sel = SEL_ENAB;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign pend_clr_we = bus_wr_i && (sel == SEL_PEND);

    eib_cause_bank #(.WIDTH(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .clr_we_i   (pend_clr_we),
        .clr_data_i (bus_wdata_i[NUM_SRC-1:0]),
        .pend_o     (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enab_q <= '0;
        end else if (bus_wr_i && (sel == SEL_ENAB)) begin
            enab_q <= bus_wdata_i[NUM_SRC-1:0];
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        unique case (sel)
            SEL_PEND: rdata_d = REG_W'(pend);
            SEL_ENAB: rdata_d = REG_W'(enab_q);
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd_i;
            if (bus_rd_i) begin
                rdata_q <= rdata_d;
            end
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

    // ---------------- request and index ----------------
    assign active     = pend & enab_q;
    assign active_ext = REG_W'(active);

    eib_lowest_pick #(.WIDTH(NUM_SRC)) u_pick (
        .vec_i (active),
        .any_o (any_active),
        .idx_o (low_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            idx_q <= '0;
        end else begin
            irq_q <= any_active;
            idx_q <= low_idx;
        end
    end

    assign irq_o      = irq_q;
    assign pend_idx_o = idx_q;

    // R7: the reported index was enabled and pending
    assert_idx_is_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((($past(active_ext) >> pend_idx_o) & REG_W'(1)) == REG_W'(1)));

    // R7: nothing lower was enabled and pending
    assert_idx_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (($past(active_ext) & below_mask(pend_idx_o)) == '0));

    // R6: no request without an enabled pending bit
    assert_irq_needs_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active_ext) == '0) |-> (!irq_o && pend_idx_o == '0));

    // R5: unimplemented positions never read as 1
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> ((bus_rdata_o & ~IMPL_MASK) == '0));

    // R11: one valid cycle per read strobe
    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);
endmodule

// File: tb/test_edge_irq_bridge.sv
`timescale 1ns/1ps
module test_edge_irq_bridge;
    localparam int unsigned NSRC = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic [3:0]        addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic              irq;
    logic [4:0]        idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    edge_irq_bridge #(.NUM_SRC(NSRC), .ADDR_W(4)) i_edge_irq_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .bus_addr_i   (addr),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .irq_o        (irq),
        .pend_idx_o   (idx)
    );

    // monitor: pops the scoreboard whenever read data appears
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a; rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic chk_out(input logic ei, input logic [4:0] ex, input string t);
        checks++;
        if (irq !== ei || idx !== ex) begin
            errors++;
            $display("FAIL %s irq/idx actual=%b/%0d expected=%b/%0d", t, irq, idx, ei, ex);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk_out(1'b0, 5'd0, "R1");
        rd_reg(4'h0, 32'h0, "R1");
        rd_reg(4'h4, 32'h0, "R1");

        // R2 rising edge latches; level and falling edge do not
        src[3] = 1'b1;
        idle(5);
        rd_reg(4'h0, 32'h0000_0008, "R2");
        wr_reg(4'h0, ~32'h8);
        idle(4);
        rd_reg(4'h0, 32'h0, "R2 held level");
        src[3] = 1'b0;
        idle(5);
        rd_reg(4'h0, 32'h0, "R2 falling edge");

        // R3 latch while disabled, no request
        src[5] = 1'b1;
        idle(5);
        rd_reg(4'h0, 32'h0000_0020, "R3");
        chk_out(1'b0, 5'd0, "R3");

        // R9 stale event fires on enable
        wr_reg(4'h4, 32'h0000_0020);
        idle(2);
        chk_out(1'b1, 5'd5, "R9 stale");

        // R4 write-one keeps, write-zero clears
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, 32'h0000_0020, "R4 ones");
        wr_reg(4'h0, ~32'h20);
        idle(2);
        chk_out(1'b0, 5'd0, "R6 after clear");
        rd_reg(4'h0, 32'h0, "R4 zero");

        // R9 clear before enable prevents request
        wr_reg(4'h4, 32'h0);
        src[7] = 1'b1;
        src[12] = 1'b1;
        idle(5);
        wr_reg(4'h0, ~32'h80);
        wr_reg(4'h4, 32'h0000_1280);
        idle(2);
        chk_out(1'b1, 5'd12, "R9 cleared first");

        // R7 lowest enabled pending wins; disabled lower bit skipped
        src[9] = 1'b1;
        idle(6);
        chk_out(1'b1, 5'd9, "R7 lowest");
        src[2] = 1'b1;
        idle(6);
        chk_out(1'b1, 5'd9, "R7 disabled skipped");
        wr_reg(4'h0, ~32'h200);
        idle(2);
        chk_out(1'b1, 5'd12, "R7 next");

        // R5 upper positions read 0
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_reg(4'h4, 32'h000F_FFFF, "R5 enable");
        rd_reg(4'h0, 32'h0000_1004, "R5 pending");
        idle(1);
        chk_out(1'b1, 5'd2, "R7 all enabled");

        // R10 unmapped addresses
        wr_reg(4'h8, 32'h0);
        wr_reg(4'hC, 32'h0);
        rd_reg(4'h4, 32'h000F_FFFF, "R10 enable kept");
        rd_reg(4'h0, 32'h0000_1004, "R10 pending kept");
        rd_reg(4'hC, 32'h0, "R10 read zero");

        // R8 set beats clear on the same edge
        src[15] = 1'b1;
        idle(5);
        src[15] = 1'b0;
        idle(5);
        wr_reg(4'h0, ~32'h8000);
        rd_reg(4'h0, 32'h0000_1004, "R4 clear bit15");
        @(negedge clk);
        src[15] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 4'h0; wdata = ~32'h8000; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        idle(1);
        rd_reg(4'h0, 32'h0000_9004, "R8 set wins");
        wr_reg(4'h0, ~32'h8000);
        rd_reg(4'h0, 32'h0000_1004, "R8 control clear");

        // R6 all disabled drops the request
        wr_reg(4'h4, 32'h0);
        idle(2);
        chk_out(1'b0, 5'd0, "R6 disabled");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 reads missing actual=%0d expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule